// File: doc/BRIEF.md
# Packet Source Tag Resolver

This block sits in the decode path of a wide-issue stack processor that renames stack and local-variable addresses onto reservation-station tags. Each cycle a packet of up to eight decoded slots arrives. Every slot carries two optional source addresses, one optional destination address, and one reservation-station tag that has already been reserved for it. The block decides where each source operand will come from. It can come from the closest earlier slot in the same packet that writes the same address, from the tag that the rename table returned, or from an implicit load sent to the load/store unit.

An implicit load is tagged in one of two ways. A load instruction whose memory operand misses reuses its own reserved tag. Any other miss draws a tag from a wrapping virtual-tag counter, and those tags are marked by an extra top bit. The load/store unit accepts a fixed number of requests per cycle. When a packet needs more than that, the block raises a stall. The upstream stage then holds the packet steady, and the block sends the remaining requests over the following cycles.

Resolved tags are registered. Every resolved source is a pending operand waiting on a tag, and no data value ever passes between slots inside the block.

Top module: `pkt_dep_resolver`

## Requirements
- R1: A valid source whose address equals the destination address of an earlier valid slot with a valid destination resolves to the reserved tag of the nearest such slot (highest slot index below its own). It is reported with select code 1 and tag top bit 0.
- R2: A slot's own destination and the destinations of later slots never satisfy its sources.
- R3: A valid source with no earlier in-packet writer and a rename-table hit resolves to the rename-table tag, with select code 2 and tag top bit 0.
- R4: A valid source that misses both the packet and the rename table gets select code 3 and produces an implicit load request that carries the source address and the resolved tag.
- R5: When operand 0 of a load-instruction slot that has a valid destination takes an implicit load, its tag is that slot's own reserved tag with top bit 0.
- R6: Every other implicit load gets a virtual tag: top bit 1, low bits equal to the counter value plus the source's rank among the packet's virtual-tag sources. Ranking runs by slot, then by operand. On acceptance the counter advances by the packet's number of virtual tags, modulo 2^TAG_W.
- R7: Load requests leave in source order on up to LD_PORTS ports, filling port 0 first. The stall output is high while more requests remain than the current cycle can carry. Each stalled cycle sends LD_PORTS requests.
- R8: The registered per-slot used flag equals slot valid AND destination valid. A slot with no destination leaves its reserved tag unused.
- R9: A source in an invalid slot, or with its valid bit low, gets select code 0 and tag 0, and raises no load request.
- R10: After reset there is no stall, no load request and no result, and the virtual-tag counter starts at 0.
- R11: Results appear on the cycle after a packet is accepted (valid and not stalled), as a one-cycle result-valid pulse per accepted packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pkt_vld_i | input | 1 | Packet present; held steady while stall_o is high |
| slot_vld_i | input | SLOTS | Slot holds an instruction |
| is_ld_i | input | SLOTS | Slot is a load instruction |
| dst_vld_i | input | SLOTS | Slot writes a destination |
| dst_addr_i | input | SLOTS*ADDR_W | Destination address per slot |
| src_vld_i | input | 2*SLOTS | Source valid; index = 2*slot + operand |
| src_addr_i | input | 2*SLOTS*ADDR_W | Source address per source |
| rs_tag_i | input | SLOTS*TAG_W | Reserved tag per slot |
| map_hit_i | input | 2*SLOTS | Rename-table hit per source |
| map_tag_i | input | 2*SLOTS*TAG_W | Rename-table tag per source |
| stall_o | output | 1 | More load requests remain than fit this cycle |
| ld_vld_o | output | LD_PORTS | Load request valid per port |
| ld_addr_o | output | LD_PORTS*ADDR_W | Load request address |
| ld_tag_o | output | LD_PORTS*(TAG_W+1) | Load request tag; top bit marks virtual |
| res_vld_o | output | 1 | Resolved packet valid |
| res_sel_o | output | 2*SLOTS*2 | Source select: 0 none, 1 packet, 2 rename table, 3 load |
| res_tag_o | output | 2*SLOTS*(TAG_W+1) | Resolved tag; top bit marks virtual |
| tag_used_o | output | SLOTS | Reserved tag consumed by slot |

## Verification
The bench builds the block with eight slots, 8-bit addresses drawn from only eight values, 4-bit tags and two load ports. The narrow address range makes in-packet writer collisions, self-writes and later-slot writes frequent. The 4-bit tag space lets the virtual counter wrap within a few packets, including wraps in the middle of a packet. With two ports, a packet full of misses holds the stall for seven cycles, so multi-cycle request draining and the counter's behaviour under stall are both exercised.

// File: rtl/dep_res_pkg.sv
package dep_res_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PKT  = 2'd1,
    SEL_MAP  = 2'd2,
    SEL_LD   = 2'd3
  } src_sel_e;
endpackage

// File: rtl/pkt_writer_match.sv
module pkt_writer_match #(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 6
) (
  input  logic [SLOTS-1:0]                slot_vld_i,
  input  logic [SLOTS-1:0]                dst_vld_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0]    dst_addr_i,
  input  logic [2*SLOTS-1:0][ADDR_W-1:0]  src_addr_i,
  input  logic [SLOTS-1:0][TAG_W-1:0]     rs_tag_i,
  output logic [2*SLOTS-1:0]              hit_o,
  output logic [2*SLOTS-1:0][TAG_W-1:0]   tag_o
);
  localparam int SRC_N = 2 * SLOTS;

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    localparam int OWN = s / 2;
    // later assignment wins, so the highest earlier slot is kept
    always_comb begin
      hit_o[s] = 1'b0;
      tag_o[s] = '0;
      for (int j = 0; j < OWN; j++) begin
        if (slot_vld_i[j] && dst_vld_i[j] && (dst_addr_i[j] == src_addr_i[s])) begin
          hit_o[s] = 1'b1;
          tag_o[s] = rs_tag_i[j];
        end
      end
    end
  end
endmodule

// File: rtl/src_select.sv
module src_select
  import dep_res_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int TAG_W = 6,
  parameter int CNT_W = 5
) (
  input  logic [SLOTS-1:0]               slot_vld_i,
  input  logic [SLOTS-1:0]               is_ld_i,
  input  logic [SLOTS-1:0]               dst_vld_i,
  input  logic [2*SLOTS-1:0]             src_vld_i,
  input  logic [SLOTS-1:0][TAG_W-1:0]    rs_tag_i,
  input  logic [2*SLOTS-1:0]             pkt_hit_i,
  input  logic [2*SLOTS-1:0][TAG_W-1:0]  pkt_tag_i,
  input  logic [2*SLOTS-1:0]             map_hit_i,
  input  logic [2*SLOTS-1:0][TAG_W-1:0]  map_tag_i,
  input  logic [TAG_W-1:0]               vt_base_i,
  output logic [2*SLOTS-1:0][1:0]        sel_o,
  output logic [2*SLOTS-1:0][TAG_W:0]    tag_o,
  output logic [2*SLOTS-1:0]             need_ld_o,
  output logic [CNT_W-1:0]               vt_total_o
);
  localparam int SRC_N = 2 * SLOTS;

  logic [CNT_W-1:0] vt_cnt;

  always_comb begin
    vt_cnt    = '0;
    sel_o     = '0;
    tag_o     = '0;
    need_ld_o = '0;
    for (int s = 0; s < SRC_N; s++) begin
      if (!slot_vld_i[s/2] || !src_vld_i[s]) begin
        sel_o[s] = SEL_NONE;
      end else if (pkt_hit_i[s]) begin
        sel_o[s] = SEL_PKT;
        tag_o[s] = {1'b0, pkt_tag_i[s]};
      end else if (map_hit_i[s]) begin
        sel_o[s] = SEL_MAP;
        tag_o[s] = {1'b0, map_tag_i[s]};
      end else begin
        sel_o[s]     = SEL_LD;
        need_ld_o[s] = 1'b1;
        if (is_ld_i[s/2] && dst_vld_i[s/2] && (s % 2 == 0)) begin
          tag_o[s] = {1'b0, rs_tag_i[s/2]};
        end else begin
          tag_o[s] = {1'b1, vt_base_i + vt_cnt[TAG_W-1:0]};
          vt_cnt   = vt_cnt + 1'b1;
        end
      end
    end
    vt_total_o = vt_cnt;
  end
endmodule

// File: rtl/ld_issue.sv
module ld_issue #(
  parameter int SRC_N    = 16,
  parameter int ADDR_W   = 16,
  parameter int TAG_W    = 6,
  parameter int LD_PORTS = 2,
  parameter int CNT_W    = 5
) (
  input  logic [SRC_N-1:0]               need_ld_i,
  input  logic [SRC_N-1:0][ADDR_W-1:0]   src_addr_i,
  input  logic [SRC_N-1:0][TAG_W:0]      tag_i,
  input  logic [CNT_W-1:0]               issued_i,
  output logic [LD_PORTS-1:0]            ld_vld_o,
  output logic [LD_PORTS-1:0][ADDR_W-1:0] ld_addr_o,
  output logic [LD_PORTS-1:0][TAG_W:0]   ld_tag_o,
  output logic [CNT_W-1:0]               ld_total_o
);
  logic [CNT_W-1:0] rank;

  // request with rank issued+p goes to port p
  always_comb begin
    rank      = '0;
    ld_vld_o  = '0;
    ld_addr_o = '0;
    ld_tag_o  = '0;
    for (int s = 0; s < SRC_N; s++) begin
      if (need_ld_i[s]) begin
        for (int p = 0; p < LD_PORTS; p++) begin
          if ({1'b0, rank} == {1'b0, issued_i} + (CNT_W+1)'(p)) begin
            ld_vld_o[p]  = 1'b1;
            ld_addr_o[p] = src_addr_i[s];
            ld_tag_o[p]  = tag_i[s];
          end
        end
        rank = rank + 1'b1;
      end
    end
    ld_total_o = rank;
  end
endmodule

// File: rtl/pkt_dep_resolver.sv
module pkt_dep_resolver #(
  parameter int SLOTS    = 8,
  parameter int ADDR_W   = 16,
  parameter int TAG_W    = 6,
  parameter int LD_PORTS = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             pkt_vld_i,
  input  logic [SLOTS-1:0]                 slot_vld_i,
  input  logic [SLOTS-1:0]                 is_ld_i,
  input  logic [SLOTS-1:0]                 dst_vld_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0]     dst_addr_i,
  input  logic [2*SLOTS-1:0]               src_vld_i,
  input  logic [2*SLOTS-1:0][ADDR_W-1:0]   src_addr_i,
  input  logic [SLOTS-1:0][TAG_W-1:0]      rs_tag_i,
  input  logic [2*SLOTS-1:0]               map_hit_i,
  input  logic [2*SLOTS-1:0][TAG_W-1:0]    map_tag_i,
  output logic                             stall_o,
  output logic [LD_PORTS-1:0]              ld_vld_o,
  output logic [LD_PORTS-1:0][ADDR_W-1:0]  ld_addr_o,
  output logic [LD_PORTS-1:0][TAG_W:0]     ld_tag_o,
  output logic                             res_vld_o,
  output logic [2*SLOTS-1:0][1:0]          res_sel_o,
  output logic [2*SLOTS-1:0][TAG_W:0]      res_tag_o,
  output logic [SLOTS-1:0]                 tag_used_o
);
  localparam int SRC_N = 2 * SLOTS;
  localparam int CNT_W = $clog2(SRC_N + 1);

  logic [SRC_N-1:0]             pkt_hit;
  logic [SRC_N-1:0][TAG_W-1:0]  pkt_tag;
  logic [SRC_N-1:0][1:0]        sel;
  logic [SRC_N-1:0][TAG_W:0]    tag;
  logic [SRC_N-1:0]             need_ld;
  logic [CNT_W-1:0]             vt_total;
  logic [CNT_W-1:0]             ld_total;
  logic [CNT_W-1:0]             issued_q;
  logic [TAG_W-1:0]             vt_base_q;
  logic                         accept;

  pkt_writer_match #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)
  ) match_i (
    .slot_vld_i (slot_vld_i),
    .dst_vld_i  (dst_vld_i),
    .dst_addr_i (dst_addr_i),
    .src_addr_i (src_addr_i),
    .rs_tag_i   (rs_tag_i),
    .hit_o      (pkt_hit),
    .tag_o      (pkt_tag)
  );

  src_select #(
    .SLOTS(SLOTS), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) select_i (
    .slot_vld_i (slot_vld_i & {SLOTS{pkt_vld_i}}),
    .is_ld_i    (is_ld_i),
    .dst_vld_i  (dst_vld_i),
    .src_vld_i  (src_vld_i),
    .rs_tag_i   (rs_tag_i),
    .pkt_hit_i  (pkt_hit),
    .pkt_tag_i  (pkt_tag),
    .map_hit_i  (map_hit_i),
    .map_tag_i  (map_tag_i),
    .vt_base_i  (vt_base_q),
    .sel_o      (sel),
    .tag_o      (tag),
    .need_ld_o  (need_ld),
    .vt_total_o (vt_total)
  );

  ld_issue #(
    .SRC_N(SRC_N), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
    .LD_PORTS(LD_PORTS), .CNT_W(CNT_W)
  ) issue_i (
    .need_ld_i  (need_ld),
    .src_addr_i (src_addr_i),
    .tag_i      (tag),
    .issued_i   (issued_q),
    .ld_vld_o   (ld_vld_o),
    .ld_addr_o  (ld_addr_o),
    .ld_tag_o   (ld_tag_o),
    .ld_total_o (ld_total)
  );

  assign stall_o = pkt_vld_i &&
                   ({1'b0, ld_total} > ({1'b0, issued_q} + (CNT_W+1)'(LD_PORTS)));
  assign accept  = pkt_vld_i && !stall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issued_q   <= '0;
      vt_base_q  <= '0;
      res_vld_o  <= 1'b0;
      res_sel_o  <= '0;
      res_tag_o  <= '0;
      tag_used_o <= '0;
    end else begin
      issued_q  <= stall_o ? issued_q + CNT_W'(LD_PORTS) : '0;
      res_vld_o <= accept;
      if (accept) begin
        vt_base_q  <= vt_base_q + vt_total[TAG_W-1:0];
        res_sel_o  <= sel;
        res_tag_o  <= tag;
        tag_used_o <= slot_vld_i & dst_vld_i;
      end
    end
  end
endmodule

// File: rtl/pkt_dep_resolver_chk.sv
module pkt_dep_resolver_chk #(
  parameter int SRC_N    = 16,
  parameter int TAG_W    = 6,
  parameter int LD_PORTS = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       pkt_vld_i,
  input logic                       stall_o,
  input logic [LD_PORTS-1:0]        ld_vld_o,
  input logic                       res_vld_o,
  input logic [SRC_N-1:0][1:0]      res_sel_o,
  input logic [SRC_N-1:0][TAG_W:0]  res_tag_o
);
  a_r7_stall_needs_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> pkt_vld_i);

  a_r7_stall_fills_ports: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ($countones(ld_vld_o) == LD_PORTS));

  a_r4_req_needs_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ld_vld_o) |-> pkt_vld_i);

  for (genvar p = 0; p + 1 < LD_PORTS; p++) begin : g_port
    a_r7_ports_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_vld_o[p+1] |-> ld_vld_o[p]);
  end

  a_r11_result_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_vld_i && !stall_o) |=> res_vld_o);

  a_r11_no_spurious_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_vld_i && !stall_o) |=> !res_vld_o);

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    a_r9_none_has_zero_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_vld_o && res_sel_o[s] == 2'd0) |-> (res_tag_o[s] == '0));
    a_r6_virtual_only_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_vld_o && res_tag_o[s][TAG_W]) |-> (res_sel_o[s] == 2'd3));
  end
endmodule

bind pkt_dep_resolver pkt_dep_resolver_chk #(
  .SRC_N(2*SLOTS), .TAG_W(TAG_W), .LD_PORTS(LD_PORTS)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pkt_vld_i (pkt_vld_i),
  .stall_o   (stall_o),
  .ld_vld_o  (ld_vld_o),
  .res_vld_o (res_vld_o),
  .res_sel_o (res_sel_o),
  .res_tag_o (res_tag_o)
);

// File: tb/pkt_dep_resolver_tb_top.sv
module pkt_dep_resolver_tb_top;
  localparam int SLOTS = 8;
  localparam int AW    = 8;
  localparam int TW    = 4;
  localparam int LDP   = 2;
  localparam int SN    = 2 * SLOTS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                     pkt_vld = 1'b0;
  logic [SLOTS-1:0]         slot_vld = '0, is_ld = '0, dst_vld = '0;
  logic [SLOTS-1:0][AW-1:0] dst_addr = '0;
  logic [SN-1:0]            src_vld = '0, map_hit = '0;
  logic [SN-1:0][AW-1:0]    src_addr = '0;
  logic [SLOTS-1:0][TW-1:0] rs_tag = '0;
  logic [SN-1:0][TW-1:0]    map_tag = '0;
  logic                     stall;
  logic [LDP-1:0]           ld_vld;
  logic [LDP-1:0][AW-1:0]   ld_addr;
  logic [LDP-1:0][TW:0]     ld_tag;
  logic                     res_vld;
  logic [SN-1:0][1:0]       res_sel;
  logic [SN-1:0][TW:0]      res_tag;
  logic [SLOTS-1:0]         tag_used;

  pkt_dep_resolver #(.SLOTS(SLOTS), .ADDR_W(AW), .TAG_W(TW), .LD_PORTS(LDP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pkt_vld_i(pkt_vld), .slot_vld_i(slot_vld),
    .is_ld_i(is_ld), .dst_vld_i(dst_vld), .dst_addr_i(dst_addr), .src_vld_i(src_vld),
    .src_addr_i(src_addr), .rs_tag_i(rs_tag), .map_hit_i(map_hit), .map_tag_i(map_tag),
    .stall_o(stall), .ld_vld_o(ld_vld), .ld_addr_o(ld_addr), .ld_tag_o(ld_tag),
    .res_vld_o(res_vld), .res_sel_o(res_sel), .res_tag_o(res_tag), .tag_used_o(tag_used)
  );

  int checks = 0;
  int errors = 0;
  int vt_m = 0;
  int exp_sel[SN];
  int exp_tag[SN];
  int q_addr[$];
  int q_tag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int sel, input int tag);
    if (sel == 0) return "R9";
    if (sel == 1) return "R1";
    if (sel == 2) return "R3";
    if (tag >= (1 << TW)) return "R6";
    return "R5";
  endfunction

  // behavioural reference: resolve every source of the current packet
  task automatic model();
    int nvt = 0;
    q_addr.delete();
    q_tag.delete();
    for (int s = 0; s < SN; s++) begin
      int sl = s / 2;
      int wr = -1;
      exp_sel[s] = 0;
      exp_tag[s] = 0;
      if (slot_vld[sl] && src_vld[s]) begin
        for (int j = 0; j < sl; j++)
          if (slot_vld[j] && dst_vld[j] && dst_addr[j] == src_addr[s]) wr = j;
        if (wr >= 0) begin
          exp_sel[s] = 1; exp_tag[s] = rs_tag[wr];
        end else if (map_hit[s]) begin
          exp_sel[s] = 2; exp_tag[s] = map_tag[s];
        end else begin
          exp_sel[s] = 3;
          if (is_ld[sl] && dst_vld[sl] && (s % 2 == 0)) exp_tag[s] = rs_tag[sl];
          else begin
            exp_tag[s] = (1 << TW) | ((vt_m + nvt) % (1 << TW));
            nvt++;
          end
          q_addr.push_back(src_addr[s]);
          q_tag.push_back(exp_tag[s]);
        end
      end
    end
    vt_m = (vt_m + nvt) % (1 << TW);
  endtask

  task automatic run_pkt();
    int chunk = 0;
    bit exp_stall;
    @(negedge clk);
    model();
    pkt_vld = 1'b1;
    #2;
    forever begin
      exp_stall = q_addr.size() > (chunk + 1) * LDP;
      chk(stall == exp_stall, "R7", "stall", stall, exp_stall);
      for (int p = 0; p < LDP; p++) begin
        int idx = chunk * LDP + p;
        if (idx < q_addr.size())
          chk(ld_vld[p] && ld_addr[p] == q_addr[idx] && ld_tag[p] == q_tag[idx],
              "R4", $sformatf("port%0d addr/tag(tag shown)", p), ld_vld[p] ? ld_tag[p] : -1,
              q_tag[idx]);
        else
          chk(!ld_vld[p], "R7", $sformatf("port%0d idle", p), ld_vld[p], 0);
      end
      @(posedge clk);
      if (!exp_stall) break;
      chunk++;
      #2;
    end
    #2;
    chk(res_vld == 1'b1, "R11", "res_vld after accept", res_vld, 1);
    for (int s = 0; s < SN; s++) begin
      chk(res_sel[s] == exp_sel[s], req_of(exp_sel[s], exp_tag[s]),
          $sformatf("sel src%0d", s), res_sel[s], exp_sel[s]);
      chk(res_tag[s] == exp_tag[s], req_of(exp_sel[s], exp_tag[s]),
          $sformatf("tag src%0d", s), res_tag[s], exp_tag[s]);
    end
    chk(tag_used == (slot_vld & dst_vld), "R8", "tag_used", tag_used, slot_vld & dst_vld);
    @(negedge clk);
    pkt_vld = 1'b0;
    @(posedge clk);
    #2;
    chk(res_vld == 1'b0, "R11", "res_vld single pulse", res_vld, 0);
  endtask

  task automatic clear_pkt();
    slot_vld = '0; is_ld = '0; dst_vld = '0; dst_addr = '0;
    src_vld = '0; src_addr = '0; map_hit = '0; map_tag = '0;
    for (int i = 0; i < SLOTS; i++) rs_tag[i] = TW'(i + 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_pkt();
    #2;
    chk(stall == 1'b0 && ld_vld == '0 && res_vld == 1'b0, "R10", "reset outputs",
        {stall, ld_vld, res_vld}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: chain of writers, self-write, later writer
    clear_pkt();
    slot_vld = 8'h0F; dst_vld = 8'h0F;
    dst_addr[0] = 8'd5; dst_addr[1] = 8'd5; dst_addr[2] = 8'd7; dst_addr[3] = 8'd9;
    src_vld[2] = 1'b1; src_addr[2] = 8'd5;            // slot1 reads slot0
    src_vld[4] = 1'b1; src_addr[4] = 8'd5;            // slot2 nearest is slot1
    src_vld[5] = 1'b1; src_addr[5] = 8'd7;            // R2: own dst only, map hit
    map_hit[5] = 1'b1; map_tag[5] = 4'hA;
    src_vld[0] = 1'b1; src_addr[0] = 8'd9;            // R2: later writer only, map hit
    map_hit[0] = 1'b1; map_tag[0] = 4'h6;
    src_vld[6] = 1'b1; src_addr[6] = 8'd9;            // own dst, miss -> virtual
    run_pkt();
    chk(res_sel[5] == 2 && res_sel[0] == 2, "R2", "self/later not matched", res_sel[5], 2);

    // R5: load instruction operand 0 reuses own tag; operand 1 virtual
    clear_pkt();
    slot_vld = 8'h03; is_ld = 8'h03; dst_vld = 8'h01;
    src_vld[0] = 1'b1; src_addr[0] = 8'd40;
    src_vld[1] = 1'b1; src_addr[1] = 8'd41;
    src_vld[2] = 1'b1; src_addr[2] = 8'd42;           // load without dst -> virtual
    run_pkt();

    // R6 / R7: every source misses, long stall, counter wraps
    repeat (2) begin
      clear_pkt();
      slot_vld = '1;
      src_vld = '1;
      for (int s = 0; s < SN; s++) src_addr[s] = AW'(100 + s);
      run_pkt();
    end

    // R9: invalid slots and sources with addresses that would match
    clear_pkt();
    slot_vld = 8'b1010_1010; dst_vld = '1; src_vld = 16'h5555;
    for (int s = 0; s < SN; s++) src_addr[s] = 8'd1;
    for (int i = 0; i < SLOTS; i++) dst_addr[i] = 8'd1;
    run_pkt();

    // random packets over a small address range
    for (int n = 0; n < 300; n++) begin
      clear_pkt();
      slot_vld = SLOTS'($urandom); is_ld = SLOTS'($urandom); dst_vld = SLOTS'($urandom);
      src_vld = SN'($urandom); map_hit = SN'($urandom) & SN'($urandom);
      for (int i = 0; i < SLOTS; i++) begin
        dst_addr[i] = AW'($urandom_range(0, 7));
        rs_tag[i] = TW'($urandom);
      end
      for (int s = 0; s < SN; s++) begin
        src_addr[s] = AW'($urandom_range(0, 7));
        map_tag[s] = TW'($urandom);
      end
      run_pkt();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule